// File: doc/BRIEF.md
# Delayed Single-Tick Pulse Launcher

This block is one output channel of a timing controller. It emits a pulse one clock tick wide a programmable number of clocks after a launch. A launch has two possible sources. One is a host request made through the channel's control register. The other is an external start event, such as a trigger accept, that arrives as a one-cycle strobe already synchronous to the system clock.

In free-running mode, every external start launches the channel. In single-cycle mode, an external start launches it only after the host has armed it, and only once per arming. Both launch paths share one delay countdown. While a countdown runs, or while the pulse is high, any new launch is dropped. The host sees two pending flags, one for an immediate request and one for an armed request. Both flags clear together on the edge where the pulse fires, whatever caused it.

A global test-mode input hands the output over to an external test-pattern level. The normal-mode logic keeps running underneath and its pulse is not seen.

Top module: `pulse_launcher`

## Requirements
- R1: While reset is asserted at a clock edge, the countdown stops and both pending flags clear. The normal-mode output is low and the readback is all zero after that edge.
- R2: The delay is the 4-bit value in readback/write bits 3:0. A launch sampled at edge E with delay D drives the output high from edge E+D to edge E+D+1, so D=0 gives a pulse on the first edge. The pulse is exactly one clock wide.
- R3: A write with bit 4 set requests an immediate launch. Readback bit 8 shows the request as pending until the pulse fires.
- R4: With mode bit 7 at 0, every external start that finds the channel idle launches it.
- R5: With mode bit 7 at 1, an external start launches only if an armed request is pending. Readback bit 9 shows that pending request. A write with bit 5 set arms the channel. A start with no pending arm produces no pulse.
- R6: A write that clears bit 5 after arming does not cancel the pending armed request. The next external start still launches.
- R7: On the edge where the pulse fires, both pending flags clear, whichever path launched it. A request written on that same edge is absorbed.
- R8: A launch that arrives while a countdown runs or while the output is high is ignored and causes no extra pulse.
- R9: While the test-mode input is high, the output equals the test-level input.
- R10: Readback holds the delay in bits 3:0, the immediate bit in bit 4, the arm bit in bit 5, a spare R/W bit in bit 6, the mode in bit 7, and the two pending flags in bits 8 and 9. A write's delay applies to a launch on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 10 | Control readback with pending flags |
| ext_start | input | 1 | One-cycle external start event |
| test_mode | input | 1 | Global test-mode select |
| test_level | input | 1 | Test-pattern level used in test mode |
| pulse_out | output | 1 | Channel output |

## Verification
The bench goes after the edges of the delay rule. A delay of zero must fire on the first edge, and an off-by-one counter shifts every pulse by a cycle. It also aims launches at the edge where a pulse fires and at the cycle right after it. A design that re-triggered there would produce a two-tick pulse or leave a pending flag set. Single-cycle mode is tested with a start that has not been armed, and with an arm that the host cleared before the start. A design that keyed on the stored arm bit instead of the pending flag would fire in the first case and miss in the second.

// File: rtl/pl_pkg.sv
// Package: shared widths and control field positions for the pulse launcher.
// Assumes one 8-bit write word and a 10-bit readback word.
package pl_pkg;
    localparam int DLY_W    = 4;
    localparam int WR_W     = 8;
    localparam int RD_W     = 10;
    localparam int B_IMM    = 4;
    localparam int B_ARM    = 5;
    localparam int B_SPARE  = 6;
    localparam int B_MODE   = 7;
    localparam int B_PIMM   = 8;
    localparam int B_PARM   = 9;
endpackage

// File: rtl/pl_ctrl_regs.sv
// Control register bank: stores the host fields and tracks both pending
// flags. Assumes fire is the same-edge firing strobe from the delay chain;
// a clear on fire wins over a request set on that edge.
module pl_ctrl_regs
    import pl_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             fire,
    output logic [DW-1:0]    delay_q,
    output logic             mode_q,
    output logic             imm_pend,
    output logic             arm_pend,
    output logic [RD_W-1:0]  rd_data
);
    logic imm_bit_q, arm_bit_q, spare_q;
    logic req_imm, req_arm;

    assign req_imm = wr_en && wr_data[B_IMM];
    assign req_arm = wr_en && wr_data[B_ARM];

    // Purpose: capture host-written fields on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_q   <= '0;
            imm_bit_q <= 1'b0;
            arm_bit_q <= 1'b0;
            spare_q   <= 1'b0;
            mode_q    <= 1'b0;
        end else if (wr_en) begin
            delay_q   <= wr_data[DW-1:0];
            imm_bit_q <= wr_data[B_IMM];
            arm_bit_q <= wr_data[B_ARM];
            spare_q   <= wr_data[B_SPARE];
            mode_q    <= wr_data[B_MODE];
        end
    end

    // Purpose: set pending flags on requests, clear both when the pulse fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_pend <= 1'b0;
            arm_pend <= 1'b0;
        end else if (fire) begin
            imm_pend <= 1'b0;
            arm_pend <= 1'b0;
        end else begin
            imm_pend <= imm_pend | req_imm;
            arm_pend <= arm_pend | req_arm;
        end
    end

    // Purpose: assemble the readback word.
    always_comb begin
        rd_data          = '0;
        rd_data[DW-1:0]  = delay_q;
        rd_data[B_IMM]   = imm_bit_q;
        rd_data[B_ARM]   = arm_bit_q;
        rd_data[B_SPARE] = spare_q;
        rd_data[B_MODE]  = mode_q;
        rd_data[B_PIMM]  = imm_pend;
        rd_data[B_PARM]  = arm_pend;
    end
endmodule

// File: rtl/pl_launch_sel.sv
// Launch selector: merges the immediate request and the external start,
// gated by the mode and the armed flag. Also picks the delay in force.
// Assumes ext_start is already a one-cycle synchronous event.
module pl_launch_sel
    import pl_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          wr_en,
    input  logic          wr_imm,
    input  logic [DW-1:0] wr_delay,
    input  logic          ext_start,
    input  logic          mode_q,
    input  logic          arm_pend,
    input  logic [DW-1:0] delay_q,
    output logic          launch,
    output logic [DW-1:0] launch_delay
);
    logic ext_ok;

    // Purpose: qualify the external start and merge both launch sources.
    always_comb begin
        ext_ok       = ext_start && (!mode_q || arm_pend);
        launch       = (wr_en && wr_imm) || ext_ok;
        launch_delay = wr_en ? wr_delay : delay_q;
    end
endmodule

// File: rtl/pl_delay_chain.sv
// Delay chain: accepts a launch when idle, counts down the delay and
// registers a one-tick pulse. Assumes launches during a countdown or
// during the pulse tick are to be dropped.
module pl_delay_chain
    import pl_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [DW-1:0] launch_delay,
    output logic          busy,
    output logic          pulse_q,
    output logic          fire
);
    logic [DW-1:0] cnt_q;
    logic          accept;

    // Purpose: decide acceptance and the firing edge.
    always_comb begin
        accept = launch && !busy && !pulse_q;
        fire   = (busy && (cnt_q == '0)) || (accept && (launch_delay == '0));
    end

    // Purpose: run the countdown and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
            if (busy) begin
                if (cnt_q == '0) busy  <= 1'b0;
                else             cnt_q <= cnt_q - 1'b1;
            end else if (accept && (launch_delay != '0)) begin
                busy  <= 1'b1;
                cnt_q <= launch_delay - 1'b1;
            end
        end
    end
endmodule

// File: rtl/pulse_launcher.sv
// Top: one delayed single-tick pulse channel with an immediate path and an
// armed single-shot path, plus the test-mode output select.
// Assumes all inputs are synchronous to clk.
module pulse_launcher
    import pl_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [WR_W-1:0] ctl_wdata,
    output logic [RD_W-1:0] ctl_rdata,
    input  logic            ext_start,
    input  logic            test_mode,
    input  logic            test_level,
    output logic            pulse_out
);
    logic [DW-1:0] delay_q, launch_delay;
    logic          mode_q, imm_pend, arm_pend;
    logic          launch, busy, pulse_q, fire;

    pl_ctrl_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_data(ctl_wdata),
        .fire(fire), .delay_q(delay_q), .mode_q(mode_q),
        .imm_pend(imm_pend), .arm_pend(arm_pend), .rd_data(ctl_rdata)
    );

    pl_launch_sel #(.DW(DW)) u_sel (
        .wr_en(ctl_wr), .wr_imm(ctl_wdata[B_IMM]), .wr_delay(ctl_wdata[DW-1:0]),
        .ext_start(ext_start), .mode_q(mode_q), .arm_pend(arm_pend),
        .delay_q(delay_q), .launch(launch), .launch_delay(launch_delay)
    );

    pl_delay_chain #(.DW(DW)) u_chain (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_delay(launch_delay),
        .busy(busy), .pulse_q(pulse_q), .fire(fire)
    );

    // Purpose: hand the output to the test pattern in test mode.
    always_comb pulse_out = test_mode ? test_level : pulse_q;
endmodule

// File: rtl/pl_checker.sv
// Checker: temporal properties of the pulse launcher, bound to the top.
module pl_checker
    import pl_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            ctl_wr,
    input logic [WR_W-1:0] ctl_wdata,
    input logic            ext_start,
    input logic            busy,
    input logic            pulse_q,
    input logic            imm_pend,
    input logic            arm_pend,
    input logic            mode_q,
    input logic            launch
);
    logic past_valid = 1'b0;
    always_ff @(posedge clk) past_valid <= 1'b1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        (past_valid && !$past(rst_n)) |-> (!pulse_q && !busy && !imm_pend && !arm_pend));

    assert_one_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

    assert_fire_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> ($past(busy) || $past(launch)));

    assert_imm_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[B_IMM] && !busy && !pulse_q && (ctl_wdata[3:0] != 4'd0))
        |=> (busy && imm_pend));

    assert_unarmed_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_start && mode_q && !arm_pend && !busy && !pulse_q && !(ctl_wr && ctl_wdata[B_IMM]))
        |=> (!pulse_q && !busy));

    assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> (!imm_pend && !arm_pend));
endmodule

bind pulse_launcher pl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ext_start(ext_start), .busy(busy), .pulse_q(pulse_q),
    .imm_pend(imm_pend), .arm_pend(arm_pend), .mode_q(mode_q), .launch(launch)
);

// File: tb/sim_pulse_launcher.sv
// Bench: directed corner cases followed by seeded random traffic, checked
// against a behavioural model built from the requirements.
module sim_pulse_launcher;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       ext_start = 1'b0;
    logic       test_mode = 1'b0;
    logic       test_level = 1'b0;
    logic [9:0] ctl_rdata;
    logic       pulse_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string tag = "R1";

    // model state
    int   n_edge = 0;
    bit   m_sched = 0;
    int   m_fire_at = 0;
    bit   m_pulse = 0;
    bit   m_pimm = 0, m_parm = 0;
    logic [3:0] m_dly = 0;
    bit   m_ibit = 0, m_abit = 0, m_spare = 0, m_mode = 0;

    always #2 clk = ~clk;

    pulse_launcher u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .ext_start(ext_start), .test_mode(test_mode),
        .test_level(test_level), .pulse_out(pulse_out)
    );

    function automatic logic [9:0] exp_rd();
        return {m_parm, m_pimm, m_mode, m_spare, m_abit, m_ibit, m_dly};
    endfunction

    function automatic logic exp_out();
        return test_mode ? test_level : m_pulse;
    endfunction

    // Apply one edge of the specification to the model.
    task automatic model_edge(input bit wr, input logic [7:0] wd, input bit ext, input bit rs);
        bit req_i, req_a, acc, fire_now;
        logic [3:0] eff;
        n_edge++;
        if (!rs) begin
            m_sched = 0; m_pulse = 0; m_pimm = 0; m_parm = 0;
            m_dly = 0; m_ibit = 0; m_abit = 0; m_spare = 0; m_mode = 0;
            return;
        end
        req_i = wr && wd[4];
        req_a = wr && wd[5];
        eff   = wr ? wd[3:0] : m_dly;
        acc   = (req_i || (ext && (!m_mode || m_parm))) && !m_sched && !m_pulse;
        fire_now = (m_sched && m_fire_at == n_edge) || (acc && eff == 0);
        if (m_sched && m_fire_at == n_edge) m_sched = 0;
        if (acc && eff != 0) begin m_sched = 1; m_fire_at = n_edge + int'(eff); end
        m_pulse = fire_now;
        m_pimm = fire_now ? 1'b0 : (m_pimm | req_i);
        m_parm = fire_now ? 1'b0 : (m_parm | req_a);
        if (wr) begin
            m_dly = wd[3:0]; m_ibit = wd[4]; m_abit = wd[5]; m_spare = wd[6]; m_mode = wd[7];
        end
    endtask

    task automatic check(input string what, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s edge %0d: actual %h expected %h", tag, what, n_edge, act, exp);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input bit wr, input logic [7:0] wd, input bit ext);
        ctl_wr = wr; ctl_wdata = wd; ext_start = ext;
        @(posedge clk);
        model_edge(wr, wd, ext, rst_n);
        @(negedge clk);
        ctl_wr = 1'b0; ext_start = 1'b0;
        check("out", {9'b0, pulse_out}, {9'b0, exp_out()});
        check("rdata", ctl_rdata, exp_rd());
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        tag = "R1"; rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        check("reset out", {9'b0, pulse_out}, 10'd0);
        check("reset rdata", ctl_rdata, 10'd0);
        // R2/R3: immediate request with delay 3, then delay 0 and delay 1
        tag = "R3"; step(1'b1, 8'h13, 1'b0); idle(5);
        tag = "R2"; step(1'b1, 8'h10, 1'b0); idle(3);
        step(1'b1, 8'h11, 1'b0); idle(3);
        // R4: free mode, several starts
        tag = "R4"; step(1'b1, 8'h02, 1'b0);
        for (int i = 0; i < 3; i++) begin step(1'b0, 8'h00, 1'b1); idle(4); end
        // R8: extra launches during countdown and right after the pulse
        tag = "R8"; step(1'b1, 8'h05, 1'b0);
        step(1'b0, 8'h00, 1'b1); idle(1); step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'h15, 1'b0); idle(1); step(1'b0, 8'h00, 1'b1); idle(4);
        step(1'b1, 8'h00, 1'b0); step(1'b0, 8'h00, 1'b1); step(1'b0, 8'h00, 1'b1); idle(3);
        // R5: single-cycle mode
        tag = "R5"; step(1'b1, 8'h82, 1'b0); step(1'b0, 8'h00, 1'b1); idle(3);
        step(1'b1, 8'hA2, 1'b0); idle(2); step(1'b0, 8'h00, 1'b1); idle(4);
        step(1'b0, 8'h00, 1'b1); idle(3);
        // R6: arm then clear the arm bit, start still launches
        tag = "R6"; step(1'b1, 8'hA3, 1'b0); step(1'b1, 8'h83, 1'b0); idle(2);
        step(1'b0, 8'h00, 1'b1); idle(5);
        // R7: arm and immediate together; pulse clears both; request on fire edge absorbed
        tag = "R7"; step(1'b1, 8'hB2, 1'b0); step(1'b0, 8'h00, 1'b0);
        step(1'b1, 8'hB2, 1'b0); idle(4);
        // R10: spare bit readback and same-edge delay
        tag = "R10"; step(1'b1, 8'h47, 1'b0); step(1'b1, 8'h01, 1'b1); idle(3);
        // R9: test mode overrides output
        tag = "R9"; test_mode = 1'b1;
        step(1'b1, 8'h10, 1'b0);
        for (int i = 0; i < 6; i++) begin test_level = ~test_level; step(1'b0, 8'h00, 1'b1); end
        test_mode = 1'b0; test_level = 1'b0; idle(2);
        // Random traffic
        tag = "R2";
        void'($urandom(32'd20511));
        for (int i = 0; i < 4000; i++) begin
            bit wr, ext;
            logic [7:0] wd;
            wr  = ($urandom % 8) == 0;
            ext = ($urandom % 4) == 0;
            wd  = 8'($urandom);
            if (($urandom % 200) == 0) test_mode = ~test_mode;
            test_level = 1'($urandom);
            if (($urandom % 500) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            step(wr, wd, ext);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule